// File: doc/BRIEF.md
# Four-Mode Down-Counting Interval Timer

This block is a 14-bit down counter that shapes one output line from a loaded count. A host writes a count value and a two-bit mode into holding registers, then issues a start command; the timer copies the held values into its working state and steps the counter down by one on every clock. Depending on the mode, the output is either a square wave (high for the upper half of the count, low for the lower half) or a single one-clock low pulse at terminal count. Each shape can run once and stop, or reload itself and repeat indefinitely.

A stop command freezes the counter at once and returns the output to its resting high level. The live count value is always visible on a read port, so software can watch the interval elapse. Counts below two cannot form a valid waveform and are refused. Mode encoding: bit 1 chooses the pulse shape (1) or square shape (0); bit 0 chooses repeat (1) or one-shot (0).

Top module: `tmr14_top`

## Requirements
- R1: After reset the output is high, the count reads 0 and the timer is idle.
- R2: A configuration write stores count and mode for the next start only; a write while the timer runs leaves the running waveform and its period unchanged.
- R3: A start with a stored count N of at least 2 makes the count read N in the cycle after the start, then one less on each following clock.
- R4: A start with a stored count of 0 or 1 leaves the timer idle, the count reading 0 and the output high.
- R5: Mode 00 (single square cycle): the output is high for (N+1)/2 clocks (integer division), then low for N/2 clocks, then the timer goes idle with the count reading 0 and the output high.
- R6: Mode 01 (continuous square wave): the mode 00 cycle repeats with period N, the count reloading to N after it reads 1.
- R7: Mode 10 (single terminal pulse): the output is high while the count reads N down to 2, low for exactly the one clock in which it reads 1, then the timer goes idle with the count reading 0 and the output high.
- R8: Mode 11 (repeating terminal pulse): the one-clock low pulse recurs every N clocks, the count reloading to N after it reads 1.
- R9: A stop command halts counting in the next cycle, holds the count at its value and drives the output high; it wins over a start in the same cycle.
- R10: A start issued while the timer runs restarts it from the stored count and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock; every edge is one count step |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Strobe to store cfg_count and cfg_mode |
| cfg_count | input | 14 | Count value to hold for the next start |
| cfg_mode | input | 2 | Mode to hold: bit1 pulse/square, bit0 repeat/once |
| cmd_start | input | 1 | Load held values and begin counting |
| cmd_stop | input | 1 | Halt counting, output high |
| tmr_out | output | 1 | Timer waveform output, rests high |
| cur_count | output | 14 | Live counter value |

## Verification
A wrong counter value shows on the count read port in the very next cycle and shifts every later output edge, so an off-by-one in decrement or reload surfaces within one period. A wrong half-point threshold moves the falling edge of the square wave, which a sweep over both odd and even counts catches at the first cycle of each run. A mis-decoded repeat bit shows one period after start, when the output either keeps toggling or stays high and the count reads 0 instead of N.

// File: rtl/tmr14_pkg.sv
package tmr14_pkg;

   typedef enum logic [1:0] {
      TM_SQ_ONCE    = 2'b00,
      TM_SQ_LOOP    = 2'b01,
      TM_PULSE_ONCE = 2'b10,
      TM_PULSE_LOOP = 2'b11
   } tm_mode_e;

   function automatic logic tm_repeats(input tm_mode_e m);
      return m[0];
   endfunction

   function automatic logic tm_is_pulse(input tm_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/tmr14_cfg_regs.sv
module tmr14_cfg_regs
   import tmr14_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_count,
   input  logic [1:0]       wr_mode,
   output logic [CNT_W-1:0] held_count,
   output tm_mode_e         held_mode
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_count <= '0;
         held_mode  <= TM_SQ_ONCE;
      end else if (wr_en) begin
         held_count <= wr_count;
         held_mode  <= tm_mode_e'(wr_mode);
      end
   end

endmodule

// File: rtl/tmr14_down_counter.sv
module tmr14_down_counter
   import tmr14_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [CNT_W-1:0] held_count,
   input  tm_mode_e         held_mode,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] reload,
   output logic             running,
   output logic             pulse_shape
);

   localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(2);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   tm_mode_e mode_q;
   logic     legal_start;
   logic     at_terminal;

   assign legal_start = held_count >= MIN_CNT;
   assign at_terminal = cnt == ONE;
   assign pulse_shape = tm_is_pulse(mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         reload  <= '0;
         running <= 1'b0;
         mode_q  <= TM_SQ_ONCE;
      end else if (stop) begin
         running <= 1'b0;
      end else if (start) begin
         if (legal_start) begin
            cnt     <= held_count;
            reload  <= held_count;
            mode_q  <= held_mode;
            running <= 1'b1;
         end else begin
            cnt     <= '0;
            running <= 1'b0;
         end
      end else if (running) begin
         if (at_terminal) begin
            if (tm_repeats(mode_q)) begin
               cnt <= reload;
            end else begin
               cnt     <= '0;
               running <= 1'b0;
            end
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !start && !stop && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

   // R4
   illegal_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop && held_count < MIN_CNT) |=> (!running && cnt == '0));

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !start && !stop && at_terminal && mode_q[0]) |=> (running && cnt == reload));

   // R9
   stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!running && cnt == $past(cnt)));

   // R3
   in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt != '0 && cnt <= reload));

endmodule

// File: rtl/tmr14_wave_gen.sv
module tmr14_wave_gen #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] reload,
   input  logic             running,
   input  logic             pulse_shape,
   output logic             wave
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] half_point;
   logic             sq_level;
   logic             pulse_level;

   assign half_point  = reload >> 1;
   assign sq_level    = cnt > half_point;
   assign pulse_level = cnt != ONE;
   assign wave        = !running || (pulse_shape ? pulse_level : sq_level);

   // R9
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> wave);

   // R7
   pulse_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && pulse_shape && !wave) |=> wave);

endmodule

// File: rtl/tmr14_top.sv
module tmr14_top
   import tmr14_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic [1:0]       cfg_mode,
   input  logic             cmd_start,
   input  logic             cmd_stop,
   output logic             tmr_out,
   output logic [CNT_W-1:0] cur_count
);

   initial begin
      width_ok_chk: assert (CNT_W >= 2 && CNT_W <= 32);
   end

   logic [CNT_W-1:0] held_count;
   tm_mode_e         held_mode;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] reload;
   logic             running;
   logic             pulse_shape;
   logic             wave;

   tmr14_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr),
      .wr_count   (cfg_count),
      .wr_mode    (cfg_mode),
      .held_count (held_count),
      .held_mode  (held_mode)
   );

   tmr14_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (cmd_start),
      .stop        (cmd_stop),
      .held_count  (held_count),
      .held_mode   (held_mode),
      .cnt         (cnt),
      .reload      (reload),
      .running     (running),
      .pulse_shape (pulse_shape)
   );

   tmr14_wave_gen #(.CNT_W(CNT_W)) u_wave (
      .clk         (clk),
      .rst_n       (rst_n),
      .stop        (cmd_stop),
      .cnt         (cnt),
      .reload      (reload),
      .running     (running),
      .pulse_shape (pulse_shape),
      .wave        (wave)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         logic out_q;
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= 1'b1;
            else        out_q <= wave;
         end
         assign tmr_out = out_q;
      end else begin : g_out_comb
         assign tmr_out = wave;
      end
   endgenerate

   assign cur_count = cnt;

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !$past(running)) |-> tmr_out);

endmodule

// File: tb/tb_tmr14_top.sv
module tb_tmr14_top;

   localparam int W = 14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_wr = 1'b0;
   logic [W-1:0] cfg_count = '0;
   logic [1:0]   cfg_mode = 2'b00;
   logic         cmd_start = 1'b0;
   logic         cmd_stop = 1'b0;
   logic         tmr_out;
   logic [W-1:0] cur_count;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   tmr14_top #(.CNT_W(W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_count (cfg_count),
      .cfg_mode  (cfg_mode),
      .cmd_start (cmd_start),
      .cmd_stop  (cmd_stop),
      .tmr_out   (tmr_out),
      .cur_count (cur_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic write_cfg(input int n, input int m);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_count = W'(n); cfg_mode = 2'(m);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic pulse_start();
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   function automatic int exp_out(input int n, input int m, input int j);
      if (m[1]) return (j != n - 1) ? 1 : 0;
      return (j < (n + 1) / 2) ? 1 : 0;
   endfunction

   // Samples cycle i after start at each negedge; one-shot modes go idle after N.
   task automatic watch(input string req, input int n, input int m, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         int j;
         if (m[0] || i < n) begin
            j = i % n;
            chk(req, int'(cur_count), n - j);
            chk(req, int'(tmr_out), exp_out(n, m, j));
         end else begin
            chk(req, int'(cur_count), 0);
            chk(req, int'(tmr_out), 1);
         end
         @(negedge clk);
      end
   endtask

   task automatic stop_now();
      cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1", int'(tmr_out), 1);
      chk("R1", int'(cur_count), 0);

      // R5 R6 R7 R8 R3: sweep every mode over odd and even counts
      for (int m = 0; m < 4; m++) begin
         for (int n = 2; n <= 24; n++) begin
            write_cfg(n, m);
            pulse_start();
            if (m == 0) watch("R5", n, m, 2 * n + 3);
            else if (m == 1) watch("R6", n, m, 2 * n + 3);
            else if (m == 2) watch("R7", n, m, 2 * n + 3);
            else watch("R8", n, m, 2 * n + 3);
            stop_now();
         end
      end

      // R3: full-width count
      write_cfg(16383, 1);
      pulse_start();
      watch("R3", 16383, 1, 12);
      stop_now();

      // R4: counts 0 and 1 refused, also while running
      for (int n = 0; n < 2; n++) begin
         write_cfg(9, 1);
         pulse_start();
         watch("R4", 9, 1, 3);
         write_cfg(n, 3);
         pulse_start();
         for (int k = 0; k < 4; k++) begin
            chk("R4", int'(cur_count), 0);
            chk("R4", int'(tmr_out), 1);
            @(negedge clk);
         end
      end

      // R2: write during a run leaves the running wave alone
      write_cfg(6, 1);
      pulse_start();
      watch("R2", 6, 1, 3);
      cfg_wr = 1'b1; cfg_count = W'(9); cfg_mode = 2'b10;
      @(negedge clk);
      cfg_wr = 1'b0;
      for (int i = 4; i < 20; i++) begin
         chk("R2", int'(cur_count), 6 - (i % 6));
         chk("R2", int'(tmr_out), exp_out(6, 1, i % 6));
         @(negedge clk);
      end
      // R10: restart while running picks up the new stored values
      pulse_start();
      watch("R10", 9, 2, 12);

      // R9: stop with start in the same cycle; count frozen, output high
      write_cfg(10, 1);
      pulse_start();
      watch("R9", 10, 1, 7);
      cmd_stop = 1'b1; cmd_start = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0; cmd_start = 1'b0;
      for (int k = 0; k < 5; k++) begin
         chk("R9", int'(cur_count), 3);
         chk("R9", int'(tmr_out), 1);
         @(negedge clk);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule